// File: doc/BRIEF.md
# Pass-Through Mailbox Arbiter

This block holds a 64-byte shared buffer between a host-side bus port and a contactless RF-side port. Data moves through it in one direction at a time. One side fills the buffer while it holds ownership, and the other side drains it. When the last byte of the final 16-byte block is written, ownership passes to the draining side. When the drainer reads that same last byte, ownership passes back. Field presence is a plain input. Bus framing, RF framing and field detection are handled outside the block.

The host programs an 8-bit configuration register and can read an 8-bit status register. Both are written by a masked write: a mask byte picks the bits that change, and a data byte gives their new values. The status register is read-only, so masked writes to it are dropped. A one-cycle event pulse marks every change of the ready-for-RF flag, so host firmware can be interrupt-driven instead of polling.

Each buffer port takes requests on a valid/ready handshake. Ready is held high, so every presented request is consumed in the cycle it is valid. Responses have no back-pressure: read data arrives with a valid strobe one cycle after an accepted read, and the consumer must take it then. A refused request is also consumed; it produces no response and raises that port's error pulse one cycle later.

Top module: `ptm_mailbox`

## Requirements
- R1: A configuration write (`reg_sel`=0) sets each bit whose mask bit is 1 to the data bit and keeps the other bits. Only bit 6 (pass-through enable) and bit 0 (direction: 0 = host to RF, 1 = RF to host) exist; all other configuration bits read 0. Example: value 01h with mask 41h and data 40h becomes 40h.
- R2: Bit 6 of the configuration register can be 1 only while `field_on` is 1. A write that tries to set it with the field absent leaves it 0; the direction bit is still written.
- R3: Status bits are: bit 0 field present, bit 3 ready for RF, bit 4 ready for host, bit 5 RF locked, bit 6 host locked; all other bits are 0. Status writes (`reg_sel`=1) have no effect. The status reads 00h in reset.
- R4: When pass-through is enabled in host-to-RF direction, the host owns the buffer and status reads 41h. In RF-to-host direction, the RF side owns it and status reads 21h.
- R5: In host-to-RF direction, a host write to byte address 63 moves ownership to the RF side. Status reads 29h in the next cycle.
- R6: While status is 29h, an RF read of address 63 returns ownership to the host. Status reads 41h in the next cycle.
- R7: In RF-to-host direction, an RF write of address 63 gives ownership to the host, and status reads 51h. A host read of address 63 then returns ownership to the RF side, and status reads 21h.
- R8: Bytes written by the filling side are read back unchanged by the draining side. Read data appears with the response valid strobe one cycle after the read is accepted.
- R9: An access from the side that does not own the buffer is ignored. This includes every access while pass-through is off. It writes nothing, gives no response, and raises that side's error output for exactly one cycle in the next cycle.
- R10: When `field_on` is 0, in the next cycle pass-through is off, both lock flags and both ready flags are 0, and neither side owns the buffer.
- R11: `rdy_evt` is high for exactly the one cycle in which status bit 3 shows a new value, and never otherwise.
- R12: A configuration write that changes bit 6 or bit 0 restarts the handoff: ready flags clear and the filling side of the new direction owns the buffer, or neither side owns it if pass-through is now off. A configuration write that changes neither bit leaves ownership unchanged.
- R13: Within one cycle, field loss takes precedence over a configuration write, which takes precedence over a last-byte handoff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_on | input | 1 | RF field present |
| reg_wr_en | input | 1 | Masked register write strobe |
| reg_sel | input | 1 | 0 = configuration, 1 = status |
| reg_mask | input | 8 | Bits to change |
| reg_data | input | 8 | New values of the masked bits |
| cfg_q | output | 8 | Configuration register |
| stat_q | output | 8 | Status register |
| h_req_valid | input | 1 | Host request valid |
| h_req_ready | output | 1 | Host request ready (always 1) |
| h_req_write | input | 1 | Host request is a write |
| h_req_addr | input | 6 | Host byte address |
| h_req_wdata | input | 8 | Host write data |
| h_rsp_valid | output | 1 | Host read data valid |
| h_rsp_data | output | 8 | Host read data |
| h_err | output | 1 | Host access refused (one-cycle pulse) |
| rf_req_valid | input | 1 | RF request valid |
| rf_req_ready | output | 1 | RF request ready (always 1) |
| rf_req_write | input | 1 | RF request is a write |
| rf_req_addr | input | 6 | RF byte address |
| rf_req_wdata | input | 8 | RF write data |
| rf_rsp_valid | output | 1 | RF read data valid |
| rf_rsp_data | output | 8 | RF read data |
| rf_err | output | 1 | RF access refused (one-cycle pulse) |
| rdy_evt | output | 1 | Ready-for-RF flag changed |

## Verification
The bench uses the default shape of four 16-byte blocks. It is small enough that every byte address is written and read back in both transfer directions, and every handoff happens on address 63.

The 8-bit register width allows every one of the 256 mask values to be applied to the configuration register against an arithmetic model. Each write is checked against the restart and ownership status that follows it. A shorter sweep shows status writes having no effect.

Same-cycle collisions are driven directly: a configuration write together with a last-byte write, and field loss together with a configuration write. Field loss is also applied while the RF side owns a full buffer.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
  localparam int REG_W        = 8;
  localparam int CFG_PT       = 6;
  localparam int CFG_DIR      = 0;
  localparam int ST_FIELD     = 0;
  localparam int ST_RDY_RF    = 3;
  localparam int ST_RDY_HOST  = 4;
  localparam int ST_RF_LOCK   = 5;
  localparam int ST_HOST_LOCK = 6;
  localparam logic [REG_W-1:0] CFG_IMPL = 8'h41;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_H2R_FILL,
    PH_H2R_DRAIN,
    PH_R2H_FILL,
    PH_R2H_DRAIN
  } phase_e;
endpackage

// File: rtl/ptm_cfg_reg.sv
module ptm_cfg_reg
  import ptm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             field_on,
  input  logic             wr_en,
  input  logic             sel,
  input  logic [REG_W-1:0] mask,
  input  logic [REG_W-1:0] data,
  output logic [REG_W-1:0] cfg_q,
  output logic [REG_W-1:0] cfg_d,
  output logic             cfg_load
);
  logic [REG_W-1:0] merged;
  logic             cfg_wr;

  assign cfg_wr = wr_en && !sel;

  always_comb begin
    merged = ((cfg_q & ~mask) | (data & mask)) & CFG_IMPL;
    if (!field_on) merged[CFG_PT] = 1'b0;
    cfg_d = cfg_wr ? merged : cfg_q;
    if (!field_on) cfg_d[CFG_PT] = 1'b0;
    cfg_load = field_on && cfg_wr &&
               ((merged[CFG_PT] != cfg_q[CFG_PT]) || (merged[CFG_DIR] != cfg_q[CFG_DIR]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assert_masked_dir_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel) |=> cfg_q[CFG_DIR] == ($past(mask[CFG_DIR]) ? $past(data[CFG_DIR]) : $past(cfg_q[CFG_DIR])));

  assert_pt_needs_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !field_on |=> !cfg_q[CFG_PT]);

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q & ~CFG_IMPL) == '0);
endmodule

// File: rtl/ptm_port_gate.sv
module ptm_port_gate #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic          write,
  input  logic [AW-1:0] addr,
  input  logic          owns,
  output logic          do_wr,
  output logic          do_rd,
  output logic          last_wr,
  output logic          last_rd,
  output logic          err_q
);
  localparam logic [AW-1:0] LAST_ADDR = {AW{1'b1}};

  logic at_last;

  assign at_last = (addr == LAST_ADDR);
  assign do_wr   = valid && write && owns;
  assign do_rd   = valid && !write && owns;
  assign last_wr = do_wr && at_last;
  assign last_rd = do_rd && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= valid && !owns;
  end
endmodule

// File: rtl/ptm_phase_fsm.sv
module ptm_phase_fsm
  import ptm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             field_on,
  input  logic             cfg_load,
  input  logic [REG_W-1:0] cfg_d,
  input  logic             h_last_wr,
  input  logic             h_last_rd,
  input  logic             r_last_wr,
  input  logic             r_last_rd,
  output logic             host_owns,
  output logic             rf_owns,
  output logic [REG_W-1:0] own_bits,
  output logic             evt_q
);
  phase_e phase, nxt;

  always_comb begin
    nxt = phase;
    if (!field_on) begin
      nxt = PH_IDLE;
    end else if (cfg_load) begin
      if (!cfg_d[CFG_PT])      nxt = PH_IDLE;
      else if (cfg_d[CFG_DIR]) nxt = PH_R2H_FILL;
      else                     nxt = PH_H2R_FILL;
    end else begin
      case (phase)
        PH_H2R_FILL:  if (h_last_wr) nxt = PH_H2R_DRAIN;
        PH_H2R_DRAIN: if (r_last_rd) nxt = PH_H2R_FILL;
        PH_R2H_FILL:  if (r_last_wr) nxt = PH_R2H_DRAIN;
        PH_R2H_DRAIN: if (h_last_rd) nxt = PH_R2H_FILL;
        default:      nxt = phase;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      evt_q <= 1'b0;
    end else begin
      phase <= nxt;
      evt_q <= (nxt == PH_H2R_DRAIN) != (phase == PH_H2R_DRAIN);
    end
  end

  assign host_owns = (phase == PH_H2R_FILL) || (phase == PH_R2H_DRAIN);
  assign rf_owns   = (phase == PH_H2R_DRAIN) || (phase == PH_R2H_FILL);

  always_comb begin
    own_bits = '0;
    own_bits[ST_HOST_LOCK] = host_owns;
    own_bits[ST_RF_LOCK]   = rf_owns;
    own_bits[ST_RDY_RF]    = (phase == PH_H2R_DRAIN);
    own_bits[ST_RDY_HOST]  = (phase == PH_R2H_DRAIN);
  end

  assert_no_drain_without_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_H2R_DRAIN) && !$past(phase == PH_H2R_DRAIN) |-> $past(h_last_wr) && $past(field_on));

  assert_idle_after_loss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !field_on |=> !host_owns && !rf_owns);
endmodule

// File: rtl/ptm_buffer.sv
module ptm_buffer #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_we,
  input  logic          a_re,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic          a_rvalid,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic          b_re,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic          b_rvalid,
  output logic [DW-1:0] b_rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we)      mem[a_addr] <= a_wdata;
    else if (b_we) mem[b_addr] <= b_wdata;
    if (a_re) a_rdata <= mem[a_addr];
    if (b_re) b_rdata <= mem[b_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rvalid <= 1'b0;
      b_rvalid <= 1'b0;
    end else begin
      a_rvalid <= a_re;
      b_rvalid <= b_re;
    end
  end

  assert_single_writer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_we && b_we));
endmodule

// File: rtl/ptm_mailbox.sv
module ptm_mailbox
  import ptm_pkg::*;
#(
  parameter int BLK_BYTES = 16,
  parameter int NUM_BLKS  = 4,
  parameter int DW        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             field_on,
  input  logic             reg_wr_en,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_mask,
  input  logic [REG_W-1:0] reg_data,
  output logic [REG_W-1:0] cfg_q,
  output logic [REG_W-1:0] stat_q,
  input  logic             h_req_valid,
  output logic             h_req_ready,
  input  logic             h_req_write,
  input  logic [5:0]       h_req_addr,
  input  logic [DW-1:0]    h_req_wdata,
  output logic             h_rsp_valid,
  output logic [DW-1:0]    h_rsp_data,
  output logic             h_err,
  input  logic             rf_req_valid,
  output logic             rf_req_ready,
  input  logic             rf_req_write,
  input  logic [5:0]       rf_req_addr,
  input  logic [DW-1:0]    rf_req_wdata,
  output logic             rf_rsp_valid,
  output logic [DW-1:0]    rf_rsp_data,
  output logic             rf_err,
  output logic             rdy_evt
);
  localparam int DEPTH = BLK_BYTES * NUM_BLKS;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic [REG_W-1:0] cfg_d, own_bits;
  logic             cfg_load, host_owns, rf_owns, field_q;
  logic             h_wr, h_rd, h_lw, h_lr;
  logic             r_wr, r_rd, r_lw, r_lr;

  assign h_req_ready  = 1'b1;
  assign rf_req_ready = 1'b1;

  ptm_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .field_on(field_on), .wr_en(reg_wr_en), .sel(reg_sel),
    .mask(reg_mask), .data(reg_data), .cfg_q(cfg_q), .cfg_d(cfg_d), .cfg_load(cfg_load)
  );

  ptm_port_gate #(.AW(AW)) u_hgate (
    .clk(clk), .rst_n(rst_n), .valid(h_req_valid), .write(h_req_write), .addr(h_req_addr),
    .owns(host_owns), .do_wr(h_wr), .do_rd(h_rd), .last_wr(h_lw), .last_rd(h_lr), .err_q(h_err)
  );

  ptm_port_gate #(.AW(AW)) u_rgate (
    .clk(clk), .rst_n(rst_n), .valid(rf_req_valid), .write(rf_req_write), .addr(rf_req_addr),
    .owns(rf_owns), .do_wr(r_wr), .do_rd(r_rd), .last_wr(r_lw), .last_rd(r_lr), .err_q(rf_err)
  );

  ptm_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .field_on(field_on), .cfg_load(cfg_load), .cfg_d(cfg_d),
    .h_last_wr(h_lw), .h_last_rd(h_lr), .r_last_wr(r_lw), .r_last_rd(r_lr),
    .host_owns(host_owns), .rf_owns(rf_owns), .own_bits(own_bits), .evt_q(rdy_evt)
  );

  ptm_buffer #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .a_we(h_wr), .a_re(h_rd), .a_addr(h_req_addr), .a_wdata(h_req_wdata),
    .a_rvalid(h_rsp_valid), .a_rdata(h_rsp_data),
    .b_we(r_wr), .b_re(r_rd), .b_addr(rf_req_addr), .b_wdata(rf_req_wdata),
    .b_rvalid(rf_rsp_valid), .b_rdata(rf_rsp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) field_q <= 1'b0;
    else        field_q <= field_on;
  end

  always_comb begin
    stat_q = own_bits;
    stat_q[ST_FIELD] = field_q;
  end

  assert_handoff_to_rf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == 8'h41 && field_on && !reg_wr_en && h_req_valid && h_req_write && h_req_addr == LAST_ADDR)
    |=> stat_q == 8'h29);

  assert_return_to_host_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == 8'h29 && field_on && !reg_wr_en && rf_req_valid && !rf_req_write && rf_req_addr == LAST_ADDR)
    |=> stat_q == 8'h41);

  assert_r2h_handoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == 8'h21 && field_on && !reg_wr_en && rf_req_valid && rf_req_write && rf_req_addr == LAST_ADDR)
    |=> stat_q == 8'h51);

  assert_field_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !field_on |=> (stat_q == 8'h00) && !cfg_q[CFG_PT]);

  assert_reject_host_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req_valid && !stat_q[ST_HOST_LOCK]) |=> h_err && !h_rsp_valid);

  assert_reject_rf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_req_valid && !stat_q[ST_RF_LOCK]) |=> rf_err && !rf_rsp_valid);

  assert_read_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req_valid && !h_req_write && stat_q[ST_HOST_LOCK]) |=> h_rsp_valid);

  assert_evt_on_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_evt |-> stat_q[ST_RDY_RF] != $past(stat_q[ST_RDY_RF]));

  assert_status_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_sel && field_on && stat_q[ST_FIELD] && !h_req_valid && !rf_req_valid)
    |=> stat_q == $past(stat_q));
endmodule

// File: tb/ptm_mailbox_test.sv
module ptm_mailbox_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       field_on = 1'b1;
  logic       reg_wr_en = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_mask = '0, reg_data = '0;
  logic [7:0] cfg_q, stat_q;
  logic       h_req_valid = 1'b0, h_req_write = 1'b0, h_req_ready;
  logic [5:0] h_req_addr = '0;
  logic [7:0] h_req_wdata = '0, h_rsp_data;
  logic       h_rsp_valid, h_err;
  logic       rf_req_valid = 1'b0, rf_req_write = 1'b0, rf_req_ready;
  logic [5:0] rf_req_addr = '0;
  logic [7:0] rf_req_wdata = '0, rf_rsp_data;
  logic       rf_rsp_valid, rf_err, rdy_evt;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ptm_mailbox uut (
    .clk(clk), .rst_n(rst_n), .field_on(field_on), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_mask(reg_mask), .reg_data(reg_data), .cfg_q(cfg_q), .stat_q(stat_q),
    .h_req_valid(h_req_valid), .h_req_ready(h_req_ready), .h_req_write(h_req_write),
    .h_req_addr(h_req_addr), .h_req_wdata(h_req_wdata), .h_rsp_valid(h_rsp_valid),
    .h_rsp_data(h_rsp_data), .h_err(h_err),
    .rf_req_valid(rf_req_valid), .rf_req_ready(rf_req_ready), .rf_req_write(rf_req_write),
    .rf_req_addr(rf_req_addr), .rf_req_wdata(rf_req_wdata), .rf_rsp_valid(rf_rsp_valid),
    .rf_rsp_data(rf_rsp_data), .rf_err(rf_err), .rdy_evt(rdy_evt)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1'b0; h_req_valid = 1'b0; rf_req_valid = 1'b0;
  endtask

  task automatic reg_wr(input bit sel, input logic [7:0] m, input logic [7:0] d);
    reg_wr_en = 1'b1; reg_sel = sel; reg_mask = m; reg_data = d;
    step();
  endtask

  task automatic host_acc(input bit wr, input int a, input logic [7:0] d);
    h_req_valid = 1'b1; h_req_write = wr; h_req_addr = 6'(a); h_req_wdata = d;
    step();
  endtask

  task automatic rf_acc(input bit wr, input int a, input logic [7:0] d);
    rf_req_valid = 1'b1; rf_req_write = wr; rf_req_addr = 6'(a); rf_req_wdata = d;
    step();
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((i * (2 * seed + 5)) + seed * 29 + 3);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] cm, exp_cfg, exp_st, dv;
    repeat (3) @(negedge clk);
    check(cfg_q == 8'h00, "R3 reset cfg", cfg_q, 0);
    check(stat_q == 8'h00, "R3 reset status", stat_q, 0);
    check(!h_err && !rf_err && !rdy_evt, "R9 reset pulses", {h_err, rf_err, rdy_evt}, 0);
    rst_n = 1'b1;
    step();
    check(stat_q == 8'h01, "R3 field bit", stat_q, 8'h01);

    // R1 worked example
    reg_wr(0, 8'h41, 8'h01);
    check(cfg_q == 8'h01, "R1 set dir", cfg_q, 8'h01);
    reg_wr(0, 8'h41, 8'h40);
    check(cfg_q == 8'h40, "R1 example 01->40", cfg_q, 8'h40);
    check(stat_q == 8'h41, "R4 host owns", stat_q, 8'h41);

    // R1/R12 full mask sweep
    cm = cfg_q;
    for (int m = 0; m < 256; m++) begin
      dv = 8'(m) ^ 8'hC3 ^ 8'(m >> 3);
      reg_wr(0, 8'(m), dv);
      exp_cfg = ((cm & ~8'(m)) | (dv & 8'(m))) & 8'h41;
      cm = exp_cfg;
      exp_st = exp_cfg[6] ? (exp_cfg[0] ? 8'h21 : 8'h41) : 8'h01;
      check(cfg_q == exp_cfg, "R1 mask sweep cfg", cfg_q, exp_cfg);
      check(stat_q == exp_st, "R12 mask sweep status", stat_q, exp_st);
      check(!rdy_evt, "R11 no event on fill", rdy_evt, 0);
    end

    // R3 status writes ignored
    reg_wr(0, 8'h41, 8'h40);
    for (int k = 0; k < 16; k++) begin
      reg_wr(1, 8'(k * 17), ~8'(k * 17));
      check(stat_q == 8'h41, "R3 status write ignored", stat_q, 8'h41);
      check(cfg_q == 8'h40, "R3 cfg untouched", cfg_q, 8'h40);
    end

    // host-to-RF rounds
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < 64; i++) begin
        host_acc(1, i, pat(r, i));
        check(!h_err, "R9 owner write no error", h_err, 0);
        if (i < 63) check(stat_q == 8'h41, "R4 status while filling", stat_q, 8'h41);
      end
      check(stat_q == 8'h29, "R5 terminator handoff", stat_q, 8'h29);
      check(rdy_evt, "R11 event on rise", rdy_evt, 1);
      host_acc(1, 5, 8'hEE);
      check(h_err, "R9 host refused", h_err, 1);
      check(!rdy_evt, "R11 single-cycle event", rdy_evt, 0);
      step();
      check(!h_err, "R9 error one cycle", h_err, 0);
      for (int i = 0; i < 64; i++) begin
        rf_acc(0, i, 8'h00);
        check(rf_rsp_valid && rf_rsp_data == pat(r, i), "R8 RF readback", rf_rsp_data, pat(r, i));
      end
      check(stat_q == 8'h41, "R6 back to host", stat_q, 8'h41);
      check(rdy_evt, "R11 event on fall", rdy_evt, 1);
    end
    rf_acc(0, 3, 8'h00);
    check(rf_err && !rf_rsp_valid, "R9 RF refused while host owns", rf_err, 1);

    // R12 restart mid-fill, then RF-to-host
    for (int i = 0; i < 20; i++) host_acc(1, i, 8'h11);
    reg_wr(0, 8'h01, 8'h01);
    check(stat_q == 8'h21, "R12 restart to RF fill", stat_q, 8'h21);
    check(!rdy_evt, "R11 no event without ready", rdy_evt, 0);
    for (int i = 0; i < 64; i++) rf_acc(1, i, pat(7, i));
    check(stat_q == 8'h51, "R7 RF handoff to host", stat_q, 8'h51);
    check(!rdy_evt, "R11 no event on host ready", rdy_evt, 0);
    reg_wr(0, 8'h80, 8'h80);
    check(stat_q == 8'h51 && cfg_q == 8'h41, "R12 neutral write keeps owner", stat_q, 8'h51);
    rf_acc(1, 0, 8'hFF);
    check(rf_err, "R9 RF refused while host drains", rf_err, 1);
    for (int i = 0; i < 64; i++) begin
      host_acc(0, i, 8'h00);
      check(h_rsp_valid && h_rsp_data == pat(7, i), "R8 host readback", h_rsp_data, pat(7, i));
    end
    check(stat_q == 8'h21, "R7 back to RF", stat_q, 8'h21);

    // R13 config beats terminator
    reg_wr(0, 8'h01, 8'h00);
    check(stat_q == 8'h41, "R12 direction change", stat_q, 8'h41);
    for (int i = 0; i < 63; i++) host_acc(1, i, 8'h22);
    reg_wr_en = 1'b1; reg_sel = 1'b0; reg_mask = 8'h40; reg_data = 8'h00;
    host_acc(1, 63, 8'h22);
    check(stat_q == 8'h01 && cfg_q == 8'h00, "R13 config over terminator", stat_q, 8'h01);
    check(!rdy_evt, "R13 no event", rdy_evt, 0);

    // R13 field loss beats config; R2
    field_on = 1'b0;
    reg_wr(0, 8'h41, 8'h41);
    check(cfg_q == 8'h01, "R13 R2 enable refused without field", cfg_q, 8'h01);
    check(stat_q == 8'h00, "R10 status without field", stat_q, 0);
    reg_wr(0, 8'h40, 8'h40);
    check(cfg_q == 8'h01, "R2 enable refused", cfg_q, 8'h01);
    host_acc(1, 0, 8'h00);
    check(h_err, "R9 idle access refused", h_err, 1);

    // R10 field loss while RF owns
    field_on = 1'b1;
    reg_wr(0, 8'h41, 8'h40);
    check(stat_q == 8'h41, "R4 reenable", stat_q, 8'h41);
    for (int i = 0; i < 64; i++) host_acc(1, i, 8'h33);
    check(stat_q == 8'h29, "R5 full again", stat_q, 8'h29);
    field_on = 1'b0;
    step();
    check(stat_q == 8'h00 && cfg_q == 8'h00, "R10 field loss clears", stat_q, 0);
    check(rdy_evt, "R11 event on loss", rdy_evt, 1);
    field_on = 1'b1;
    step();
    check(stat_q == 8'h01, "R10 idle after return", stat_q, 8'h01);
    rf_acc(0, 63, 8'h00);
    check(rf_err && !rf_rsp_valid, "R9 RF refused when idle", rf_err, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule